// File: doc/BRIEF.md
# Bit-Serial Macro Operation Sequencer

This block turns one macro command into an ordered stream of 32-bit single-bit micro-instructions for a bit-serial compute array. The array stores each element of a vector along a row, with the bits of the element in separate columns. A micro-instruction names up to three columns. The array applies that one-bit step to every row at once. Each row has a carry latch and a tag latch. The tag can block the write-back in its row.

A command gives an operation (add, subtract, unsigned multiply or pattern search), an operand width N from 1 to 32, and base columns for operand A, operand B, the result D and a scratch area S. Search also takes a pattern. The sequencer never shifts data. A multi-bit shift is done by offsetting column addresses, and the tag latch predicates the steps where a processor would branch. Each micro-instruction waits on a valid/ready handshake. A one-cycle done pulse marks the end of the stream. A command that would address a column above 255 is refused with an error pulse, and nothing is emitted for it.

Top module: `bitserial_seq`

## Requirements
- R1: Micro-instruction word: bits [7:0] destination column, [15:8] B column, [23:16] A column, [27:24] opcode, [31:28] enables. Enable bit 28 means write back only where the tag is 1, and enable bit 29 means the new tag is the old tag AND the compare result. Opcodes: 0 ADD, 1 COPY, 2 NOT, 3 carry reset, 4 carry set, 5 store carry to destination, 6 load tag from A, 7 EQUAL (column A against bit 8 of the word), 8 set tag. Any address field an opcode does not use is 0.
- R2: Add (cmd_op 0) emits a carry reset, then N ADD steps. Step i uses A=a+i, B=b+i and D=d+i, from i=0 upward, for a total of N+1 words. D may equal a or b.
- R3: Subtract (cmd_op 1) emits N NOT steps (A=b+i, D=s+i), then a carry set, then N ADD steps (A=a+i, B=s+i, D=d+i), for 2N+1 words.
- R4: Multiply (cmd_op 2) starts with a carry reset, then 2N store-carry steps with D=d+k for k from 0 to 2N-1.
- R5: For each multiplier bit j, multiply loads the tag from column b+j. For j=0 it then emits N predicated COPY steps (A=a+i, D=d+i). For j≥1 it emits a carry reset, then N predicated ADD steps (A=a+i, B=D=d+j+i).
- R6: After each predicated add pass j≥1, multiply emits one predicated store-carry to column d+j+N. The total is 1+2N+(N+1)+(N-1)(N+3) words.
- R7: Search (cmd_op 3) emits a set-tag step, then N EQUAL steps. Step i uses A=a+i and B=pattern bit i, and carries the tag-AND enable. The total is N+1 words.
- R8: While ui_valid is high and ui_ready is low, ui_word holds its value. The stream advances by one word per cycle in which both are high.
- R9: cmd_ready is high exactly while the block is idle. A command offered while busy is ignored, and the current stream is left unchanged.
- R10: seq_done is high for one cycle, the cycle after the last word's handshake, and the block is idle in that cycle.
- R11: A command is refused if N is 0 or above 32, or if any column it would use exceeds 255. A refused command gives a one-cycle seq_err pulse in the cycle after it is offered, emits no word and raises no seq_done.
- R12: After reset, cmd_ready=1, ui_valid=0, seq_done=0 and seq_err=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle and able to take a command |
| cmd_op | input | 2 | 0 add, 1 subtract, 2 multiply, 3 search |
| cmd_width | input | 6 | Operand width N |
| cmd_base_a | input | 8 | Base column of operand A |
| cmd_base_b | input | 8 | Base column of operand B (multiplier) |
| cmd_base_d | input | 8 | Base column of the result |
| cmd_base_s | input | 8 | Base column of the scratch area |
| cmd_pattern | input | 32 | Search pattern, bit i for element bit i |
| ui_valid | output | 1 | Micro-instruction valid |
| ui_ready | input | 1 | Array accepts the micro-instruction |
| ui_word | output | 32 | Micro-instruction word |
| seq_done | output | 1 | Stream complete pulse |
| seq_err | output | 1 | Command refused pulse |

## Verification
All four operations are swept over widths 1 to 6 and two sets of base columns, and each is run once at width 32. Every emitted word is compared with a list built from the sequence rules. Half of the runs stall ui_ready in a fixed rhythm, which separates a stream that advances on the handshake from one that advances on the clock. Multiply at widths 1 and 2 exercises the edge cases of having no add pass or exactly one, and a command offered while busy shows whether the stream can be disturbed. Columns that land exactly on 255 separate the range check's edge from the first refused value. Widths 0 and 33 are also offered to confirm they are refused.

// File: rtl/bitserial_seq.sv
module bitserial_seq #(
  parameter int MAX_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  output logic                       cmd_ready,
  input  logic [1:0]                 cmd_op,
  input  logic [$clog2(MAX_W+1)-1:0] cmd_width,
  input  logic [7:0]                 cmd_base_a,
  input  logic [7:0]                 cmd_base_b,
  input  logic [7:0]                 cmd_base_d,
  input  logic [7:0]                 cmd_base_s,
  input  logic [MAX_W-1:0]           cmd_pattern,
  output logic                       ui_valid,
  input  logic                       ui_ready,
  output logic [31:0]                ui_word,
  output logic                       seq_done,
  output logic                       seq_err
);
  localparam int NW = $clog2(MAX_W+1);
  localparam int CW = $clog2(2*MAX_W+1);

  localparam logic [1:0] C_ADD = 2'd0, C_SUB = 2'd1, C_MUL = 2'd2, C_SRCH = 2'd3;
  localparam logic [3:0] U_ADD = 4'h0, U_COPY = 4'h1, U_NOT = 4'h2, U_RSTC = 4'h3,
                         U_SETC = 4'h4, U_STC = 4'h5, U_LDT = 4'h6, U_EQ = 4'h7, U_SETT = 4'h8;
  localparam logic [3:0] E_NONE = 4'b0000, E_PRED = 4'b0001, E_TAND = 4'b0010;

  typedef enum logic [3:0] {S_IDLE, S_INIT, S_INV, S_SETC, S_ZERO, S_LDT, S_PRC, S_BODY, S_STC} ph_t;

  ph_t              ph;
  logic [1:0]       op_q;
  logic [CW-1:0]    n_q, i_q, j_q;
  logic [7:0]       a_q, b_q, d_q, s_q;
  logic [MAX_W-1:0] pat_q, pat_sh;
  logic             done_q, err_q;

  assign cmd_ready = (ph == S_IDLE);
  assign ui_valid  = (ph != S_IDLE);
  assign seq_done  = done_q;
  assign seq_err   = err_q;

  wire fire   = ui_valid && ui_ready;
  wire i_last = (i_q == n_q - CW'(1));
  wire j_last = (j_q == n_q - CW'(1));
  wire z_last = (i_q == CW'(2*n_q - CW'(1)));

  logic [9:0] end_a, end_b, end_d, end_dm, end_s;
  logic       bad;
  always_comb begin
    end_a  = 10'(cmd_base_a) + 10'(cmd_width) - 10'd1;
    end_b  = 10'(cmd_base_b) + 10'(cmd_width) - 10'd1;
    end_d  = 10'(cmd_base_d) + 10'(cmd_width) - 10'd1;
    end_dm = 10'(cmd_base_d) + 10'(cmd_width) + 10'(cmd_width) - 10'd1;
    end_s  = 10'(cmd_base_s) + 10'(cmd_width) - 10'd1;
    bad = (cmd_width == '0) || (cmd_width > NW'(MAX_W)) || (end_a > 10'd255);
    case (cmd_op)
      C_ADD:   bad = bad || end_b > 10'd255 || end_d > 10'd255;
      C_SUB:   bad = bad || end_b > 10'd255 || end_d > 10'd255 || end_s > 10'd255;
      C_MUL:   bad = bad || end_b > 10'd255 || end_dm > 10'd255;
      default: ;
    endcase
  end

  function automatic logic [31:0] mk(input logic [3:0] en, input logic [3:0] op,
                                     input logic [7:0] ra, input logic [7:0] rb,
                                     input logic [7:0] rd);
    return {en, op, ra, rb, rd};
  endfunction

  wire [7:0] i8  = 8'(i_q);
  wire [7:0] j8  = 8'(j_q);
  wire [7:0] n8  = 8'(n_q);
  wire [7:0] dji = d_q + j8 + i8;
  assign pat_sh = pat_q >> i_q;

  always_comb begin
    ui_word = '0;
    case (ph)
      S_INIT: ui_word = (op_q == C_SRCH) ? mk(E_NONE, U_SETT, 8'd0, 8'd0, 8'd0)
                                         : mk(E_NONE, U_RSTC, 8'd0, 8'd0, 8'd0);
      S_INV:  ui_word = mk(E_NONE, U_NOT, b_q + i8, 8'd0, s_q + i8);
      S_SETC: ui_word = mk(E_NONE, U_SETC, 8'd0, 8'd0, 8'd0);
      S_ZERO: ui_word = mk(E_NONE, U_STC, 8'd0, 8'd0, d_q + i8);
      S_LDT:  ui_word = mk(E_NONE, U_LDT, b_q + j8, 8'd0, 8'd0);
      S_PRC:  ui_word = mk(E_NONE, U_RSTC, 8'd0, 8'd0, 8'd0);
      S_STC:  ui_word = mk(E_PRED, U_STC, 8'd0, 8'd0, d_q + j8 + n8);
      S_BODY: begin
        case (op_q)
          C_ADD:  ui_word = mk(E_NONE, U_ADD, a_q + i8, b_q + i8, d_q + i8);
          C_SUB:  ui_word = mk(E_NONE, U_ADD, a_q + i8, s_q + i8, d_q + i8);
          C_MUL:  ui_word = (j_q == '0) ? mk(E_PRED, U_COPY, a_q + i8, 8'd0, d_q + i8)
                                        : mk(E_PRED, U_ADD, a_q + i8, dji, dji);
          default: ui_word = mk(E_TAND, U_EQ, a_q + i8, {7'd0, pat_sh[0]}, 8'd0);
        endcase
      end
      default: ui_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= S_IDLE; op_q <= '0; n_q <= '0; i_q <= '0; j_q <= '0;
      a_q <= '0; b_q <= '0; d_q <= '0; s_q <= '0; pat_q <= '0;
      done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (ph == S_IDLE) begin
        if (cmd_valid) begin
          if (bad) err_q <= 1'b1;
          else begin
            op_q <= cmd_op; n_q <= CW'(cmd_width);
            a_q <= cmd_base_a; b_q <= cmd_base_b; d_q <= cmd_base_d; s_q <= cmd_base_s;
            pat_q <= cmd_pattern; i_q <= '0; j_q <= '0;
            ph <= (cmd_op == C_SUB) ? S_INV : S_INIT;
          end
        end
      end else if (fire) begin
        case (ph)
          S_INIT: begin i_q <= '0; ph <= (op_q == C_MUL) ? S_ZERO : S_BODY; end
          S_INV:  if (i_last) begin i_q <= '0; ph <= S_SETC; end else i_q <= i_q + CW'(1);
          S_SETC: ph <= S_BODY;
          S_ZERO: if (z_last) begin i_q <= '0; ph <= S_LDT; end else i_q <= i_q + CW'(1);
          S_LDT:  ph <= (j_q == '0) ? S_BODY : S_PRC;
          S_PRC:  ph <= S_BODY;
          S_BODY: begin
            if (!i_last) i_q <= i_q + CW'(1);
            else begin
              i_q <= '0;
              if (op_q != C_MUL) begin ph <= S_IDLE; done_q <= 1'b1; end
              else if (j_q != '0) ph <= S_STC;
              else if (j_last) begin ph <= S_IDLE; done_q <= 1'b1; end
              else begin j_q <= j_q + CW'(1); ph <= S_LDT; end
            end
          end
          S_STC:  if (j_last) begin ph <= S_IDLE; done_q <= 1'b1; end
                  else begin j_q <= j_q + CW'(1); ph <= S_LDT; end
          default: ph <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/bitserial_seq_chk.sv
module bitserial_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic        ui_valid,
  input logic        ui_ready,
  input logic [31:0] ui_word,
  input logic        seq_done,
  input logic        seq_err
);
  // R8
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ui_valid && !ui_ready |=> ui_valid && $stable(ui_word));
  // R9
  start_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ui_valid) |-> $past(cmd_valid && cmd_ready));
  // R10
  done_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> $past(ui_valid && ui_ready) && !ui_valid && cmd_ready);
  // R11
  err_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |-> $past(cmd_valid && cmd_ready) && !ui_valid && !seq_done);
  // R1
  opcode_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ui_valid |-> ui_word[27:24] <= 4'h8 && ui_word[31:30] == 2'b00);
endmodule

bind bitserial_seq bitserial_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .ui_valid(ui_valid), .ui_ready(ui_ready), .ui_word(ui_word),
  .seq_done(seq_done), .seq_err(seq_err)
);

// File: tb/bitserial_seq_tb.sv
`timescale 1ns/1ps
module bitserial_seq_tb;
  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, ui_ready = 0;
  logic cmd_ready, ui_valid, seq_done, seq_err;
  logic [1:0] cmd_op = 0;
  logic [5:0] cmd_width = 0;
  logic [7:0] cmd_base_a = 0, cmd_base_b = 0, cmd_base_d = 0, cmd_base_s = 0;
  logic [31:0] cmd_pattern = 0, ui_word;

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] exp_w [0:1299];
  int exp_n;

  always #2.5 clk = ~clk;

  bitserial_seq u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] w(input int en, input int op, input int ra, input int rb, input int rd);
    return {4'(en), 4'(op), 8'(ra), 8'(rb), 8'(rd)};
  endfunction

  task automatic push(input logic [31:0] x);
    exp_w[exp_n] = x; exp_n++;
  endtask

  task automatic build(input int op, input int n, input int a, input int b, input int d, input int s, input logic [31:0] pat);
    exp_n = 0;
    case (op)
      0: begin push(w(0,3,0,0,0)); for (int i = 0; i < n; i++) push(w(0,0,a+i,b+i,d+i)); end
      1: begin
        for (int i = 0; i < n; i++) push(w(0,2,b+i,0,s+i));
        push(w(0,4,0,0,0));
        for (int i = 0; i < n; i++) push(w(0,0,a+i,s+i,d+i));
      end
      2: begin
        push(w(0,3,0,0,0));
        for (int k = 0; k < 2*n; k++) push(w(0,5,0,0,d+k));
        for (int j = 0; j < n; j++) begin
          push(w(0,6,b+j,0,0));
          if (j == 0) for (int i = 0; i < n; i++) push(w(1,1,a+i,0,d+i));
          else begin
            push(w(0,3,0,0,0));
            for (int i = 0; i < n; i++) push(w(1,0,a+i,d+j+i,d+j+i));
            push(w(1,5,0,0,d+j+n));
          end
        end
      end
      default: begin
        push(w(0,8,0,0,0));
        for (int i = 0; i < n; i++) push(w(2,7,a+i,int'(pat[i]),0));
      end
    endcase
  endtask

  function automatic string rq(input int op);
    case (op) 0: return "R2"; 1: return "R3"; 2: return "R5"; default: return "R7"; endcase
  endfunction

  task automatic offer(input int op, input int n, input int a, input int b, input int d, input int s, input logic [31:0] pat);
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R9", 32'(cmd_ready), 1);
    cmd_op = 2'(op); cmd_width = 6'(n); cmd_base_a = 8'(a); cmd_base_b = 8'(b);
    cmd_base_d = 8'(d); cmd_base_s = 8'(s); cmd_pattern = pat; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic run_ok(input int op, input int n, input int a, input int b, input int d, input int s,
                        input logic [31:0] pat, input bit stall, input bit hammer);
    int idx = 0, bad = 0, early = 0, guard = 0;
    build(op, n, a, b, d, s, pat);
    offer(op, n, a, b, d, s, pat);
    chk(seq_err == 1'b0, "R11", 32'(seq_err), 0);
    while (idx < exp_n && guard < 20000) begin
      if (guard > 0) @(negedge clk);
      guard++; cyc++;
      ui_ready = stall ? ((cyc % 4) != 2) : 1'b1;
      if (hammer) begin
        cmd_valid = (idx < exp_n - 1); cmd_op = 2'(3 - op); cmd_base_a = 8'd7;
      end
      if (seq_done) early++;
      if (ui_valid && ui_ready) begin
        if (ui_word !== exp_w[idx] && bad < 3) begin
          bad++; chk(0, rq(op), ui_word, exp_w[idx]);
        end
        idx++;
      end
    end
    cmd_valid = 0;
    chk(bad == 0, rq(op), 32'(bad), 0);
    chk(idx == exp_n, rq(op), 32'(idx), 32'(exp_n));
    chk(early == 0, "R10", 32'(early), 0);
    if (hammer) chk(bad == 0, "R9", 32'(bad), 0);
    @(negedge clk);
    ui_ready = 0;
    chk(seq_done == 1'b1 && ui_valid == 1'b0 && cmd_ready == 1'b1, "R10", {29'd0, seq_done, ui_valid, cmd_ready}, 32'b101);
    @(negedge clk);
    chk(seq_done == 1'b0, "R10", 32'(seq_done), 0);
  endtask

  task automatic run_bad(input int op, input int n, input int a, input int b, input int d, input int s);
    offer(op, n, a, b, d, s, 32'h0);
    chk(seq_err == 1'b1 && ui_valid == 1'b0, "R11", {30'd0, seq_err, ui_valid}, 32'b10);
    ui_ready = 1;
    @(negedge clk);
    chk(seq_err == 1'b0 && seq_done == 1'b0 && ui_valid == 1'b0 && cmd_ready == 1'b1, "R11",
        {28'd0, seq_err, seq_done, ui_valid, cmd_ready}, 32'b0001);
    ui_ready = 0;
  endtask

  initial begin
    #1;
    chk(cmd_ready == 1 && ui_valid == 0 && seq_done == 0 && seq_err == 0, "R12",
        {28'd0, cmd_ready, ui_valid, seq_done, seq_err}, 32'b1000);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_ready == 1 && ui_valid == 0, "R12", {30'd0, cmd_ready, ui_valid}, 32'b10);
    for (int op = 0; op < 4; op++)
      for (int n = 1; n <= 6; n++) begin
        run_ok(op, n, 0, 16, 40, 80, 32'hA5C3_96E1 ^ 32'(n*7), 1'b0, 1'b0);
        run_ok(op, n, 3, 3, 100 + n, 200, 32'h5A3C_0F71 >> n, 1'b1, 1'b0);
      end
    // R1 R2 in-place destination plus busy command ignored
    run_ok(0, 4, 10, 20, 10, 0, 0, 1'b1, 1'b1);
    // R4 R6 widest cases
    run_ok(0, 32, 0, 32, 64, 0, 0, 1'b0, 1'b0);
    run_ok(1, 32, 0, 32, 64, 96, 0, 1'b1, 1'b0);
    run_ok(2, 32, 0, 32, 64, 0, 0, 1'b0, 1'b0);
    run_ok(3, 32, 100, 0, 0, 0, 32'hDEAD_BEEF, 1'b1, 1'b0);
    // R11 boundaries: last legal column 255, then one past
    run_ok(0, 7, 249, 249, 249, 0, 0, 1'b0, 1'b0);
    run_bad(0, 7, 250, 0, 0, 0);
    run_ok(2, 28, 0, 0, 200, 0, 0, 1'b0, 1'b0);
    run_bad(2, 28, 0, 0, 201, 0);
    run_bad(1, 4, 0, 0, 0, 253);
    run_ok(3, 1, 255, 0, 0, 0, 32'h1, 1'b0, 1'b0);
    run_bad(3, 2, 255, 0, 0, 0);
    run_bad(0, 0, 0, 0, 0, 0);
    run_bad(1, 33, 0, 0, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #900000;
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule